// File: doc/BRIEF.md
# Eight-Line Processor Interrupt Pending and Mask Unit

This block gathers eight level-sensitive interrupt request lines into a pending byte. It decides whether the processor core receives a single interrupt request. The core sees two registers through a small register port. A status word holds a global enable flag and one mask bit per line. A cause word holds the pending bits. The two lowest lines are software requests, and the processor sets or clears them by writing the cause word. The other six lines are wired to external device inputs, with device input k landing on line k+2. The core therefore cannot reach lines 0 and 1 from the device side.

The interrupt output is registered. It is high when the global enable is set and at least one pending line also has its mask bit set. For debug, the pending byte and the mask byte are also available on their own ports. Each line has a saturating event counter for statistics. A counter advances when its line newly becomes pending while that line is enabled. Software reads the counters through an index port.

Top module: `irq_pend_unit`

## Requirements
- R1: Synchronous active-low reset clears the status word, the cause word, all eight counters and `core_irq`.
- R2: Device input k appears in cause bit 10+k one clock after it is sampled. Cause bits 15:10 ignore register writes.
- R3: A write with `reg_sel`=1 loads cause bits 9:8 (lines 0 and 1) from `reg_wdata[9:8]`. Otherwise those two bits hold their value.
- R4: A write with `reg_sel`=0 loads status bits 15:8 (mask for lines 7..0) and bit 0 (global enable) from `reg_wdata`. All other status bits read as zero.
- R5: `core_irq` equals, one clock later, status bit 0 AND the OR over n of (cause bit 8+n AND status bit 8+n).
- R6: While status bit 0 is 0, `core_irq` stays low whatever the pending and mask bits are.
- R7: `dbg_pend` equals cause[15:8] and `dbg_mask` equals status[15:8]. `reg_rsel`=0 returns the status word on `reg_rdata`, and 1 returns the cause word.
- R8: The counter of line n rises by one on the clock edge where cause bit 8+n goes from 0 to 1. This happens only if status bit 0 and status bit 8+n, as held before that edge, are both 1.
- R9: A counter that has reached its all-ones value stays there instead of wrapping.
- R10: `cnt_rdata` returns the counter selected by `cnt_idx`. An index of 8 or more is ignored and reads zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| dev_irq | input | 6 | Device request levels; bit k drives line k+2 |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | Write target: 0 status, 1 cause |
| reg_wdata | input | 32 | Write data |
| reg_rsel | input | 1 | Read source: 0 status, 1 cause |
| reg_rdata | output | 32 | Selected register word |
| core_irq | output | 1 | Registered interrupt request to the core |
| dbg_pend | output | 8 | Pending byte (cause[15:8]) |
| dbg_mask | output | 8 | Mask byte (status[15:8]) |
| cnt_idx | input | 4 | Counter index |
| cnt_rdata | output | 32 | Selected counter value |

## Verification
The hardest case to reach from the ports is the one where a line turns pending on the same edge that the status word changes. The counter must then judge the edge by the status value held before the write. The bench reaches this case with a status write that turns the global enable on, issued in the same cycle as a device line rises. It then confirms that the counter did not move. Saturation is reached by building the bench with 3-bit counters and toggling one line more than seven times. The gating is swept over all 256 pending patterns, under several masks and both enable states.

// File: rtl/irqg_pkg.sv
// Package irqg_pkg
// Shared types and helpers for the interrupt pending/mask unit.
// Assumes callers pass widths that fit into the stated register word.
package irqg_pkg;

    typedef enum logic {
        SEL_STATUS = 1'b0,
        SEL_CAUSE  = 1'b1
    } reg_sel_e;

endpackage

// File: rtl/irqg_regs.sv
// Module irqg_regs
// Holds the status word (global enable + per-line mask) and the pending
// bits of the cause word. Software lines sit in the low NUM_SW pending
// positions and are written by the core; the rest follow device inputs.
// Also reports, per line, an edge where the pending bit newly rises.
// Assumes PEND_LSB + NUM_LINES <= REG_W and PEND_LSB > 0.
module irqg_regs
    import irqg_pkg::*;
#(
    parameter int NUM_LINES = 8,
    parameter int NUM_SW    = 2,
    parameter int PEND_LSB  = 8,
    parameter int REG_W     = 32
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [NUM_LINES-NUM_SW-1:0] dev_lvl,
    input  logic                        wr_en,
    input  reg_sel_e                    wr_sel,
    input  logic [REG_W-1:0]            wr_data,
    output logic [REG_W-1:0]            status_word,
    output logic [REG_W-1:0]            cause_word,
    output logic [NUM_LINES-1:0]        pend,
    output logic [NUM_LINES-1:0]        mask,
    output logic                        gen_en,
    output logic [NUM_LINES-1:0]        rise
);

    localparam int NUM_DEV = NUM_LINES - NUM_SW;

    logic [NUM_LINES-1:0] pend_d;
    logic [NUM_SW-1:0]    sw_d;
    logic                 wr_cause;
    logic                 wr_status;

    assign wr_cause  = wr_en && (wr_sel == SEL_CAUSE);
    assign wr_status = wr_en && (wr_sel == SEL_STATUS);

    // Next value of the software lines: loaded on a cause write, else held.
    always_comb begin
        sw_d = wr_cause ? wr_data[PEND_LSB +: NUM_SW] : pend[NUM_SW-1:0];
    end

    // Next pending vector: device lines above the software lines.
    assign pend_d = {dev_lvl, sw_d};

    // Newly raised pending bits on the coming edge.
    assign rise = pend_d & ~pend;

    // Pending register update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend <= '0;
        end else begin
            pend <= pend_d;
        end
    end

    // Status register update: only mask byte and global enable are stored.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask   <= '0;
            gen_en <= 1'b0;
        end else if (wr_status) begin
            mask   <= wr_data[PEND_LSB +: NUM_LINES];
            gen_en <= wr_data[0];
        end
    end

    // Assemble the visible register words with unused bits at zero.
    always_comb begin
        status_word                       = '0;
        status_word[PEND_LSB +: NUM_LINES] = mask;
        status_word[0]                    = gen_en;
        cause_word                        = '0;
        cause_word[PEND_LSB +: NUM_LINES]  = pend;
    end

    // Device lines track their inputs one clock later.
    p_dev_follow_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (pend[NUM_LINES-1:NUM_SW] == $past(dev_lvl)));

    // Software lines hold unless a cause write occurs.
    p_sw_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_cause |=> (pend[NUM_SW-1:0] == $past(pend[NUM_SW-1:0])));

    // Status only changes on a status write.
    p_status_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_status |=> $stable(status_word));

    localparam int UNUSED_DEV = NUM_DEV;

endmodule

// File: rtl/irqg_gate.sv
// Module irqg_gate
// Combines pending bits, mask bits and the global enable into one
// interrupt request and registers it once.
// Assumes all inputs come from registers in the same clock domain.
module irqg_gate #(
    parameter int NUM_LINES = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_LINES-1:0] pend,
    input  logic [NUM_LINES-1:0] mask,
    input  logic                 gen_en,
    output logic                 core_irq
);

    logic hit;

    // Any enabled line pending, qualified by the global enable.
    assign hit = gen_en && (|(pend & mask));

    // Output register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            core_irq <= 1'b0;
        end else begin
            core_irq <= hit;
        end
    end

    // With the global enable off, no request leaves the block.
    p_gate_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(gen_en)) |-> !core_irq);

    // A request needs a line that was both pending and unmasked.
    p_needs_line_r5: assert property (@(posedge clk) disable iff (!rst_n)
        core_irq |-> ($past(pend & mask) != '0));

endmodule

// File: rtl/irqg_stats.sv
// Module irqg_stats
// One saturating event counter per line. A counter advances when its
// line's pending bit newly rises while that line is enabled, judged by
// the status value held before the edge. Read through an index.
// Assumes CNT_W >= 1; an index at or above NUM_LINES reads zero.
module irqg_stats #(
    parameter int NUM_LINES = 8,
    parameter int CNT_W     = 32,
    parameter int IDX_W     = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_LINES-1:0] rise,
    input  logic [NUM_LINES-1:0] line_en,
    input  logic [IDX_W-1:0]     idx,
    output logic [CNT_W-1:0]     rdata
);

    localparam int SEL_W = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1;
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic [CNT_W-1:0] cnt_q [NUM_LINES];

    for (genvar n = 0; n < NUM_LINES; n++) begin : g_line
        logic bump;
        assign bump = rise[n] && line_en[n] && (cnt_q[n] != CNT_MAX);

        // Per-line counter with saturation.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                cnt_q[n] <= '0;
            end else if (bump) begin
                cnt_q[n] <= cnt_q[n] + 1'b1;
            end
        end

        // Saturated counters stay saturated.
        p_cnt_sat_r9: assert property (@(posedge clk) disable iff (!rst_n)
            (cnt_q[n] == CNT_MAX) |=> (cnt_q[n] == CNT_MAX));

        // Counters move by at most one per clock.
        p_cnt_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
            (cnt_q[n] != CNT_MAX) |=>
                ((cnt_q[n] == $past(cnt_q[n])) || (cnt_q[n] == $past(cnt_q[n]) + 1'b1)));

        // No count without a rising, enabled line.
        p_cnt_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
            !(rise[n] && line_en[n]) |=> $stable(cnt_q[n]));
    end

    // Indexed read; out-of-range index returns zero.
    always_comb begin
        rdata = '0;
        if (idx < IDX_W'(NUM_LINES)) begin
            rdata = cnt_q[idx[SEL_W-1:0]];
        end
    end

endmodule

// File: rtl/irq_pend_unit.sv
// Module irq_pend_unit
// Top of the eight-line interrupt pending/mask unit: register file,
// request gate and statistics counters. Device input k drives line
// k+NUM_SW. Register port: write strobe with a target select, and a
// separate read select.
// Assumes single clock domain and synchronous inputs.
module irq_pend_unit
    import irqg_pkg::*;
#(
    parameter int NUM_LINES = 8,
    parameter int NUM_SW    = 2,
    parameter int PEND_LSB  = 8,
    parameter int REG_W     = 32,
    parameter int CNT_W     = 32
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic [NUM_LINES-NUM_SW-1:0]     dev_irq,
    input  logic                            reg_wr,
    input  logic                            reg_sel,
    input  logic [REG_W-1:0]                reg_wdata,
    input  logic                            reg_rsel,
    output logic [REG_W-1:0]                reg_rdata,
    output logic                            core_irq,
    output logic [NUM_LINES-1:0]            dbg_pend,
    output logic [NUM_LINES-1:0]            dbg_mask,
    input  logic [$clog2(NUM_LINES):0]      cnt_idx,
    output logic [CNT_W-1:0]                cnt_rdata
);

    localparam int IDX_W = $clog2(NUM_LINES) + 1;

    logic [REG_W-1:0]     status_word;
    logic [REG_W-1:0]     cause_word;
    logic [NUM_LINES-1:0] pend;
    logic [NUM_LINES-1:0] mask;
    logic                 gen_en;
    logic [NUM_LINES-1:0] rise;
    logic [NUM_LINES-1:0] line_en;
    reg_sel_e             wr_sel;

    assign wr_sel = reg_sel_e'(reg_sel);

    irqg_regs #(
        .NUM_LINES (NUM_LINES),
        .NUM_SW    (NUM_SW),
        .PEND_LSB  (PEND_LSB),
        .REG_W     (REG_W)
    ) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .dev_lvl     (dev_irq),
        .wr_en       (reg_wr),
        .wr_sel      (wr_sel),
        .wr_data     (reg_wdata),
        .status_word (status_word),
        .cause_word  (cause_word),
        .pend        (pend),
        .mask        (mask),
        .gen_en      (gen_en),
        .rise        (rise)
    );

    irqg_gate #(
        .NUM_LINES (NUM_LINES)
    ) u_gate (
        .clk      (clk),
        .rst_n    (rst_n),
        .pend     (pend),
        .mask     (mask),
        .gen_en   (gen_en),
        .core_irq (core_irq)
    );

    // Per-line enable as held before the coming edge.
    assign line_en = mask & {NUM_LINES{gen_en}};

    irqg_stats #(
        .NUM_LINES (NUM_LINES),
        .CNT_W     (CNT_W),
        .IDX_W     (IDX_W)
    ) u_stats (
        .clk     (clk),
        .rst_n   (rst_n),
        .rise    (rise),
        .line_en (line_en),
        .idx     (cnt_idx),
        .rdata   (cnt_rdata)
    );

    // Register read selection.
    always_comb begin
        reg_rdata = (reg_rsel == 1'b1) ? cause_word : status_word;
    end

    assign dbg_pend = cause_word[PEND_LSB +: NUM_LINES];
    assign dbg_mask = status_word[PEND_LSB +: NUM_LINES];

    // Reset leaves the request output low.
    p_reset_quiet_r1: assert property (@(posedge clk)
        !$past(rst_n) && $past(rst_n, 2) |-> !core_irq);

endmodule

// File: tb/test_irq_pend_unit.sv
`timescale 1ns/1ps
module test_irq_pend_unit;

    localparam int CW = 3;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic [5:0]     dev_irq = '0;
    logic           reg_wr = 1'b0;
    logic           reg_sel = 1'b0;
    logic [31:0]    reg_wdata = '0;
    logic           reg_rsel = 1'b0;
    logic [31:0]    reg_rdata;
    logic           core_irq;
    logic [7:0]     dbg_pend;
    logic [7:0]     dbg_mask;
    logic [3:0]     cnt_idx = '0;
    logic [CW-1:0]  cnt_rdata;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #2.5 clk = ~clk;

    irq_pend_unit #(.CNT_W(CW)) i_irq_pend_unit (
        .clk(clk), .rst_n(rst_n), .dev_irq(dev_irq), .reg_wr(reg_wr),
        .reg_sel(reg_sel), .reg_wdata(reg_wdata), .reg_rsel(reg_rsel),
        .reg_rdata(reg_rdata), .core_irq(core_irq), .dbg_pend(dbg_pend),
        .dbg_mask(dbg_mask), .cnt_idx(cnt_idx), .cnt_rdata(cnt_rdata)
    );

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr_status(logic [31:0] d);
        reg_wr = 1'b1; reg_sel = 1'b0; reg_wdata = d;
        tick();
        reg_wr = 1'b0;
    endtask

    task automatic wr_cause(logic [31:0] d);
        reg_wr = 1'b1; reg_sel = 1'b1; reg_wdata = d;
        tick();
        reg_wr = 1'b0;
    endtask

    task automatic cnt_chk(string tag, int idx, int exp);
        cnt_idx = 4'(idx);
        #0.5;
        check(tag, 32'(cnt_rdata), 32'(exp));
    endtask

    task automatic pulse_dev(int bitn);
        dev_irq[bitn] = 1'b0; tick();
        dev_irq[bitn] = 1'b1; tick();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            n_checks++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        repeat (3) tick();
        rst_n = 1'b1;
        // R1: reset state
        reg_rsel = 1'b0; #0.5;
        check("R1 status", reg_rdata, 32'h0);
        reg_rsel = 1'b1; #0.5;
        check("R1 cause", reg_rdata, 32'h0);
        check("R1 core_irq", 32'(core_irq), 32'h0);
        for (int i = 0; i < 8; i++) cnt_chk("R1 counter", i, 0);

        // R4, R7: status write keeps mask and enable only
        wr_status(32'hFFFF_FFFF);
        reg_rsel = 1'b0; #0.5;
        check("R4 status", reg_rdata, 32'h0000_FF01);
        check("R7 dbg_mask", 32'(dbg_mask), 32'hFF);

        // R3, R2: cause write sets software lines, upper bits not writable
        wr_cause(32'hFFFF_FFFF);
        reg_rsel = 1'b1; #0.5;
        check("R3 cause sw write", reg_rdata, 32'h0000_0300);
        cnt_chk("R8 line0 count", 0, 1);
        dev_irq = 6'b000001;
        tick();
        check("R2 dev0 to line2", 32'(dbg_pend), 32'h07);
        cnt_chk("R8 line2 count", 2, 1);
        check("R5 core_irq", 32'(core_irq), 32'h1);

        // R8: more rising edges counted
        pulse_dev(0); pulse_dev(0);
        cnt_chk("R8 line2 three", 2, 3);
        // R8: masked line not counted
        wr_status(32'h0000_FB01);
        pulse_dev(0);
        cnt_chk("R8 masked no count", 2, 3);
        // R8/R6: global enable off
        wr_status(32'h0000_FF00);
        pulse_dev(0);
        cnt_chk("R8 disabled no count", 2, 3);
        check("R6 core_irq off", 32'(core_irq), 32'h0);
        // R8: enable written on same edge as rise uses old status
        reg_wr = 1'b1; reg_sel = 1'b0; reg_wdata = 32'h0000_FF01;
        dev_irq[1] = 1'b1;
        tick();
        reg_wr = 1'b0;
        cnt_chk("R8 same-edge old status", 3, 0);
        // R9: saturation
        for (int i = 0; i < 6; i++) pulse_dev(0);
        cnt_chk("R9 saturate", 2, 7);
        // R10: out-of-range index
        cnt_chk("R10 idx8", 8, 0);
        cnt_chk("R10 idx15", 15, 0);

        // R5, R6, R2, R3, R7: sweep all pending patterns
        begin
            logic [7:0] masks [6] = '{8'h00, 8'hFF, 8'h01, 8'h80, 8'h5A, 8'hA5};
            for (int m = 0; m < 6; m++) begin
                for (int e = 0; e < 2; e++) begin
                    wr_status({16'h0, masks[m], 7'h0, 1'(e)});
                    check("R7 sweep mask", 32'(dbg_mask), 32'(masks[m]));
                    for (int p = 0; p < 256; p++) begin
                        logic [7:0] pv;
                        logic       exp_irq;
                        pv = 8'(p);
                        dev_irq = pv[7:2];
                        reg_wr = 1'b1; reg_sel = 1'b1;
                        reg_wdata = 32'hFFFF_FC00 | {22'h0, pv[1:0], 8'h0};
                        tick();
                        reg_wr = 1'b0;
                        check("R2/R3 sweep pend", 32'(dbg_pend), 32'(pv));
                        exp_irq = (e == 1) && ((pv & masks[m]) != 8'h0);
                        tick();
                        check(e == 1 ? "R5 sweep irq" : "R6 sweep irq",
                              32'(core_irq), 32'(exp_irq));
                    end
                end
            end
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule